// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block gathers interrupt requests from twelve sources, ten driven by hardware lines and two raised by software, and presents one 3-bit request level to the processor. Each source has a byte-wide control register that holds an enable bit, a programmable 3-bit priority level and a pending flag. A hardware line marks its source pending on a rising edge. The source then stays pending until software clears it.

The presented level is the highest level among active sources. A general control register holds a global enable that can silence every source. When the processor acknowledges a level, the block answers one cycle later with a vector. The vector is a programmable base plus the fixed index of the winning source. When several sources share the level, the lowest index wins. For the serial source, a select bit decides whether the controller supplies the vector or hands the cycle to the serial device. The abort-switch register also shows the live state of its input line.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, `irq_level` is 0 and `vec_valid` is 0. Every source control register reads 0, the general control register reads 0 and the vector base reads 0x40.
- R2: For hardware sources 0..9 (`hw_req[i]`), a 0-to-1 transition sets pending (control bit 7). A line held high does not set pending again after it has been cleared.
- R3: Writing a control register with bit 7 = 1 clears its pending flag, and writing with bit 7 = 0 leaves the flag as it was. If a set event and a clear write fall in the same cycle, the set wins.
- R4: Sources 10 and 11 are software sources. Writing their control register with bit 6 = 1 sets pending.
- R5: A source is active only when it is pending, its enable (bit 3) is 1 and its level (bits 2:0) is nonzero. A level of 0 masks the source.
- R6: `irq_level` equals the highest level among active sources while the global enable (general control bit 4) is 1, and 0 otherwise. It follows register changes in the cycle after the clock edge that made them.
- R7: One cycle after `iack` is high, `vec_valid` pulses for one cycle. `vec_out` is then the vector base plus the lowest index among active sources whose level equals `iack_lvl` (modulo 256).
- R8: If no active source matches `iack_lvl`, or the global enable is 0, the acknowledge returns `vec_spur` = 1 with `vec_out` = 0.
- R9: When the winning source is the serial source (index 3) and its control bit 4 is 0, the acknowledge returns `vec_ext` = 1 with `vec_out` = 0. When bit 4 is 1, the controller supplies the vector.
- R10: Bit 6 of the abort source's control register (index 2) reads the current value of `hw_req[2]`, independent of the pending flag.
- R11: The register map is as follows. Addresses 0..11 are the source control registers. Address 12 is general control, where only bit 4 is kept. Address 13 is the vector base (8 bits, read/write). Addresses 14 and 15 read 0 and ignore writes. Source reads return bit 7 pending, bit 6 abort live (source 2 only), bit 4 vector select (source 3 only), bit 3 enable and bits 2:0 level, with all other bits 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hw_req | input | 10 | Request lines of hardware sources 0..9 |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address for reads and writes |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` (combinational) |
| iack | input | 1 | Acknowledge strobe from the processor |
| iack_lvl | input | 3 | Level being acknowledged |
| irq_level | output | 3 | Highest active level, 0 when none |
| vec_valid | output | 1 | Acknowledge response valid |
| vec_out | output | 8 | Returned vector |
| vec_ext | output | 1 | Serial device supplies the vector |
| vec_spur | output | 1 | No source matched the acknowledge |

## Verification
The assertions assume that the request lines are synchronous to `clk` and that `iack` is a single-cycle strobe per acknowledge. They also assume that a software source sees no activity on a hardware line, because its slot has its edge input tied low. The bench drives every input at the falling edge from a seeded generator. This keeps requests, writes and acknowledges aligned to the clock, and lets them collide freely in the same cycle, including a set and a clear landing together.

// File: rtl/pic_pkg.sv
// Package: shared constants and the per-source status type of the
// priority interrupt controller. Assumes byte-wide control registers.
package pic_pkg;
    localparam int LVL_W      = 3;
    localparam int SRC_ABORT  = 2;
    localparam int SRC_SERIAL = 3;

    localparam int B_PEND = 7;
    localparam int B_SET  = 6;
    localparam int B_SEL  = 4;
    localparam int B_EN   = 3;

    typedef struct packed {
        logic             pend;
        logic             en;
        logic [LVL_W-1:0] lvl;
    } src_stat_t;
endpackage

// File: rtl/pic_src_slot.sv
// Module: one interrupt source slot. It holds the control fields, captures
// rising edges of its request line, and takes set/clear writes.
// Assumes: req_in is synchronous to clk; software slots get req_in tied 0.
module pic_src_slot
    import pic_pkg::*;
#(
    parameter bit SW_SRC   = 1'b0,
    parameter bit HAS_LIVE = 1'b0,
    parameter bit HAS_SEL  = 1'b0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_in,
    input  logic       wr_hit,
    input  logic       wr_clr,
    input  logic       wr_set,
    input  logic       wr_sel,
    input  logic       wr_en_bit,
    input  logic [2:0] wr_lvl,
    output src_stat_t  stat,
    output logic [7:0] rd_byte
);
    logic prev_q, pend_q, en_q, sel_q;
    logic [LVL_W-1:0] lvl_q;
    logic set_ev;

    // Set event: a hardware rising edge or a software set write.
    always_comb set_ev = (req_in && !prev_q) || (SW_SRC && wr_hit && wr_set);

    // State update: edge history, pending flag (set beats clear), and fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= req_in;
            pend_q <= 1'b0;
            en_q   <= 1'b0;
            lvl_q  <= '0;
            sel_q  <= 1'b0;
        end else begin
            prev_q <= req_in;
            if (set_ev)
                pend_q <= 1'b1;
            else if (wr_hit && wr_clr)
                pend_q <= 1'b0;
            if (wr_hit) begin
                en_q  <= wr_en_bit;
                lvl_q <= wr_lvl;
                sel_q <= wr_sel;
            end
        end
    end

    // Status out and read-back byte.
    always_comb begin
        stat    = '{pend: pend_q, en: en_q, lvl: lvl_q};
        rd_byte = '0;
        rd_byte[B_PEND]  = pend_q;
        rd_byte[B_SET]   = HAS_LIVE ? req_in : 1'b0;
        rd_byte[B_SEL]   = HAS_SEL ? sel_q : 1'b0;
        rd_byte[B_EN]    = en_q;
        rd_byte[2:0]     = lvl_q;
    end

    // R3
    clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && wr_clr && !(req_in && !prev_q) && !(SW_SRC && wr_set)) |=> !pend_q);

    // R2
    hw_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!SW_SRC && $rose(pend_q)) |-> $past(req_in));

    // R4
    sw_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (SW_SRC && $rose(pend_q)) |-> $past(wr_hit && wr_set));
endmodule

// File: rtl/pic_resolver.sv
// Module: combinational priority resolver. It finds the highest active level,
// and the lowest-index active source at the acknowledged level.
// Assumes: a level of 0 never counts as active.
module pic_resolver
    import pic_pkg::*;
#(
    parameter int NSRC  = 12,
    parameter int IDX_W = 4
) (
    input  src_stat_t        stat [NSRC],
    input  logic             gie,
    input  logic [LVL_W-1:0] ack_lvl,
    output logic [LVL_W-1:0] top_lvl,
    output logic             hit,
    output logic [IDX_W-1:0] hit_idx
);
    logic [NSRC-1:0] act;

    // Active mask: pending, enabled, nonzero level, global enable on.
    always_comb
        for (int i = 0; i < NSRC; i++)
            act[i] = stat[i].pend && stat[i].en && (stat[i].lvl != '0) && gie;

    // Highest level across active sources.
    always_comb begin
        top_lvl = '0;
        for (int i = 0; i < NSRC; i++)
            if (act[i] && stat[i].lvl > top_lvl) top_lvl = stat[i].lvl;
    end

    // Lowest matching index for the acknowledged level (scan downwards).
    always_comb begin
        hit     = 1'b0;
        hit_idx = '0;
        for (int i = NSRC - 1; i >= 0; i--)
            if (act[i] && stat[i].lvl == ack_lvl) begin
                hit     = 1'b1;
                hit_idx = IDX_W'(i);
            end
    end
endmodule

// File: rtl/prio_irq_ctrl.sv
// Module: top of the vectored priority interrupt controller. It decodes
// register access, builds the source slots, and answers acknowledges
// one cycle later.
// Assumes: iack is a one-cycle strobe; reads are combinational on addr.
module prio_irq_ctrl
    import pic_pkg::*;
#(
    parameter int         NSRC    = 12,
    parameter int         NHW     = 10,
    parameter int         ADDR_W  = 4,
    parameter logic [7:0] VEC_RST = 8'h40
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NHW-1:0]   hw_req,
    input  logic             wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]       wdata,
    output logic [7:0]       rdata,
    input  logic             iack,
    input  logic [LVL_W-1:0] iack_lvl,
    output logic [LVL_W-1:0] irq_level,
    output logic             vec_valid,
    output logic [7:0]       vec_out,
    output logic             vec_ext,
    output logic             vec_spur
);
    localparam int IDX_W = $clog2(NSRC);
    localparam logic [ADDR_W-1:0] GEN_A  = ADDR_W'(NSRC);
    localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(NSRC + 1);

    src_stat_t        stat [NSRC];
    logic [7:0]       rd_b [NSRC];
    logic             gie;
    logic [7:0]       vec_base;
    logic [LVL_W-1:0] top_lvl;
    logic             hit, ext_now;
    logic [IDX_W-1:0] hit_idx;

    // Source slots: hardware slots see their line, software slots a tied 0.
    for (genvar i = 0; i < NSRC; i++) begin : g_src
        logic req_i;
        if (i < NHW) begin : g_hw
            assign req_i = hw_req[i];
        end else begin : g_sw
            assign req_i = 1'b0;
        end
        pic_src_slot #(
            .SW_SRC   (i >= NHW),
            .HAS_LIVE (i == SRC_ABORT),
            .HAS_SEL  (i == SRC_SERIAL)
        ) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .req_in    (req_i),
            .wr_hit    (wr_en && addr == ADDR_W'(i)),
            .wr_clr    (wdata[B_PEND]),
            .wr_set    (wdata[B_SET]),
            .wr_sel    (wdata[B_SEL]),
            .wr_en_bit (wdata[B_EN]),
            .wr_lvl    (wdata[2:0]),
            .stat      (stat[i]),
            .rd_byte   (rd_b[i])
        );
    end

    // General control and vector base registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gie      <= 1'b0;
            vec_base <= VEC_RST;
        end else if (wr_en) begin
            if (addr == GEN_A)  gie      <= wdata[B_SEL];
            if (addr == BASE_A) vec_base <= wdata;
        end
    end

    // Read multiplexer.
    always_comb begin
        rdata = '0;
        for (int i = 0; i < NSRC; i++)
            if (addr == ADDR_W'(i)) rdata = rd_b[i];
        if (addr == GEN_A)  rdata = {3'b000, gie, 4'b0000};
        if (addr == BASE_A) rdata = vec_base;
    end

    pic_resolver #(.NSRC(NSRC), .IDX_W(IDX_W)) u_res (
        .stat    (stat),
        .gie     (gie),
        .ack_lvl (iack_lvl),
        .top_lvl (top_lvl),
        .hit     (hit),
        .hit_idx (hit_idx)
    );

    assign irq_level = top_lvl;

    // Serial winner with device-supplied vector.
    always_comb
        ext_now = hit && (hit_idx == IDX_W'(SRC_SERIAL)) && !rd_b[SRC_SERIAL][B_SEL];

    // Acknowledge response register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_valid <= 1'b0;
            vec_out   <= '0;
            vec_ext   <= 1'b0;
            vec_spur  <= 1'b0;
        end else begin
            vec_valid <= iack;
            vec_ext   <= iack && ext_now;
            vec_spur  <= iack && !hit;
            vec_out   <= (iack && hit && !ext_now) ? vec_base + 8'(hit_idx) : 8'h00;
        end
    end

    // R7
    resp_follows_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> $past(iack));

    // R8
    real_vec_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_valid && !vec_spur) |-> ($past(iack_lvl) != '0));

    // R9
    ext_only_on_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vec_ext |-> (vec_valid && !vec_spur && vec_out == 8'h00));
endmodule

// File: tb/prio_irq_ctrl_bench.sv
`timescale 1ns/1ps
module prio_irq_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [9:0] hw_req = '0;
    logic       wr_en = 1'b0;
    logic [3:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       iack = 1'b0;
    logic [2:0] iack_lvl = '0;
    logic [2:0] irq_level;
    logic       vec_valid, vec_ext, vec_spur;
    logic [7:0] vec_out;

    int tests = 0, fails = 0;
    bit done = 0;

    // Reference model state
    bit       m_pend [12];
    bit       m_en   [12];
    bit [2:0] m_lvl  [12];
    bit       m_sel, m_gie;
    bit [7:0] m_base;
    bit [9:0] m_prev;
    bit       e_valid, e_spur, e_ext;
    bit [7:0] e_out;

    always #4 clk = ~clk;

    prio_irq_ctrl u_prio_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .hw_req(hw_req), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .iack(iack), .iack_lvl(iack_lvl),
        .irq_level(irq_level), .vec_valid(vec_valid), .vec_out(vec_out),
        .vec_ext(vec_ext), .vec_spur(vec_spur)
    );

    function automatic bit active(int i);
        return m_pend[i] && m_en[i] && m_lvl[i] != 0 && m_gie;
    endfunction

    function automatic int exp_level();
        int t = 0;
        for (int i = 0; i < 12; i++) if (active(i) && m_lvl[i] > t) t = m_lvl[i];
        return t;
    endfunction

    function automatic int exp_read(int a);
        if (a < 12) return (m_pend[a] << 7) | ((a == 2 ? hw_req[2] : 0) << 6) |
                           ((a == 3 ? m_sel : 0) << 4) | (m_en[a] << 3) | m_lvl[a];
        if (a == 12) return m_gie << 4;
        if (a == 13) return m_base;
        return 0;
    endfunction

    task automatic check(string tag, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 12; i++) begin m_pend[i] = 0; m_en[i] = 0; m_lvl[i] = 0; end
        m_sel = 0; m_gie = 0; m_base = 8'h40; m_prev = hw_req;
        e_valid = 0; e_spur = 0; e_ext = 0; e_out = 0;
    endtask

    // One clock: drive at negedge, update model at posedge, check at next negedge
    task automatic step(bit [9:0] req, bit we, bit [3:0] a, bit [7:0] d, bit ak, bit [2:0] al);
        int w;
        bit st;
        hw_req = req; wr_en = we; addr = a; wdata = d; iack = ak; iack_lvl = al;
        @(posedge clk);
        e_valid = ak; e_spur = 0; e_ext = 0; e_out = 0;
        if (ak) begin
            w = -1;
            for (int i = 11; i >= 0; i--) if (active(i) && m_lvl[i] == al) w = i;
            if (w < 0) e_spur = 1;
            else if (w == 3 && !m_sel) e_ext = 1;
            else e_out = m_base + 8'(w);
        end
        for (int i = 0; i < 12; i++) begin
            st = (i < 10) ? (req[i] && !m_prev[i]) : (we && a == i && d[6]);
            if (st) m_pend[i] = 1;
            else if (we && a == i && d[7]) m_pend[i] = 0;
            if (we && a == i) begin
                m_en[i] = d[3]; m_lvl[i] = d[2:0];
                if (i == 3) m_sel = d[4];
            end
        end
        if (we && a == 12) m_gie = d[4];
        if (we && a == 13) m_base = d;
        m_prev = req;
        @(negedge clk);
        wr_en = 0; iack = 0;
        check("R6 level", irq_level, exp_level());
        check("R7 valid", vec_valid, e_valid);
        if (e_valid) begin
            check("R8 spur", vec_spur, e_spur);
            check("R9 ext", vec_ext, e_ext);
            check("R7 vector", vec_out, e_out);
        end
    endtask

    task automatic wr(bit [3:0] a, bit [7:0] d);
        step(hw_req, 1, a, d, 0, 0);
    endtask

    task automatic ack(bit [2:0] l);
        step(hw_req, 0, 0, 0, 1, l);
    endtask

    task automatic rd(int a, string tag);
        addr = 4'(a);
        #1;
        check(tag, rdata, exp_read(a));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog R1 actual=%0d expected=%0d", 0, 1);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        model_reset();
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 level", irq_level, 0);
        check("R1 valid", vec_valid, 0);
        for (int a = 0; a < 16; a++) rd(a, "R1 reset read");
        check("R1 base", rdata == 8'h00 ? 0 : 1, 0);

        // R11 map: general control keeps bit 4 only, 14/15 ignore writes
        wr(12, 8'hFF); rd(12, "R11 gen");
        check("R11 gen value", rdata, 8'h10);
        wr(14, 8'hA5); rd(14, "R11 hole");
        wr(0, 8'hFF);  rd(0, "R11 src0");
        wr(0, 8'h00);

        // R2 edge capture
        wr(5, 8'h0C);
        step(10'h020, 0, 0, 0, 0, 0);
        check("R2 pend level", irq_level, 4);
        wr(5, 8'h8C);
        step(10'h020, 0, 0, 0, 0, 0);
        rd(5, "R2 no retrigger");
        check("R2 no retrigger bit", rdata[7], 0);

        // R3 clear semantics and set-beats-clear
        step(10'h000, 0, 0, 0, 0, 0);
        step(10'h020, 0, 0, 0, 0, 0);
        wr(5, 8'h0C); rd(5, "R3 bit7 zero keeps");
        check("R3 still pending", rdata[7], 1);
        step(10'h000, 0, 0, 0, 0, 0);
        step(10'h020, 1, 5, 8'h8C, 0, 0);
        rd(5, "R3 set wins");
        check("R3 set wins bit", rdata[7], 1);

        // R5 masking
        wr(5, 8'h08); check("R5 level zero masks", irq_level, 0);
        wr(5, 8'h06); check("R5 enable off masks", irq_level, 0);
        wr(5, 8'h0E); check("R5 unmasked", irq_level, 6);

        // R6 global enable
        wr(12, 8'h00); check("R6 gie off", irq_level, 0);
        wr(12, 8'h10); check("R6 gie on", irq_level, 6);

        // R4 software sources
        wr(10, 8'h4B); rd(10, "R4 sw set");
        check("R4 sw pending", rdata[7], 1);
        wr(11, 8'h4F); check("R4 sw level", irq_level, 7);
        wr(5, 8'h80); wr(10, 8'h80); wr(11, 8'h80);

        // R7 tie resolution and base change
        wr(1, 8'h0D); wr(6, 8'h0D);
        step(10'h042, 0, 0, 0, 0, 0);
        ack(5); check("R7 tie lowest idx", vec_out, 8'h41);
        wr(13, 8'h80);
        ack(5); check("R7 new base", vec_out, 8'h81);
        wr(1, 8'h8D);
        ack(5); check("R7 next winner", vec_out, 8'h86);

        // R8 spurious cases
        ack(2); check("R8 no match", vec_spur, 1);
        wr(12, 8'h00);
        ack(5); check("R8 gie off", vec_spur, 1);
        wr(12, 8'h10);

        // R9 serial vector select
        wr(3, 8'h0B);
        step(10'h008, 0, 0, 0, 0, 0);
        ack(3); check("R9 device vector", vec_ext, 1);
        wr(3, 8'h1B);
        ack(3); check("R9 ctrl vector", vec_out, 8'h83);
        rd(3, "R9 read");

        // R10 abort live state
        step(10'h004, 0, 0, 0, 0, 0);
        rd(2, "R10 live high");
        check("R10 bit6 high", rdata[6], 1);
        step(10'h000, 0, 0, 0, 0, 0);
        rd(2, "R10 live low");
        check("R10 bit6 low", rdata[6], 0);

        // Constrained random mix
        for (int n = 0; n < 3000; n++) begin
            bit [9:0] rq = 10'($urandom);
            bit we = ($urandom % 10) < 3;
            bit [3:0] a = 4'($urandom % 16);
            bit [7:0] d = 8'($urandom);
            bit ak = ($urandom % 5) == 0;
            bit [2:0] al = 3'($urandom);
            if (a == 12 && ($urandom % 2)) d[4] = 1;
            step(rq, we, a, d, ak, al);
            rd($urandom % 16, "R11 random read");
        end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule